// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card bus clock from the core clock. An 11-bit divisor value sets the divide ratio, which is always the divisor plus two, so the fastest card clock is half the core rate. With a 250 MHz core, divisor 0 yields 125 MHz, divisor 3 yields 50 MHz, divisor 7 yields roughly 27.8 MHz, and divisor 623 yields 400 kHz for card identification.

The divisor that is applied depends on the bus mode. In identification mode all 11 bits count. In data mode only the low three bits are used, which restricts the ratio to the fast range without any reprogramming. A slow-card override forces the full 11-bit divisor in every mode, for cores so fast that the short data-mode divisor cannot reach a legal card rate. Along with the card clock, the block gives single-cycle core-domain strobes marking each rising and each falling card clock edge, so that logic elsewhere can launch and capture bus bits without its own edge detection. A new divisor, mode or override value is taken only at a card clock rising edge, so a reprogram never cuts a clock phase short.

Top module: `sd_clkdiv`

## Requirements
- R1: While reset is asserted, card_clk, rise_stb and fall_stb are all 0; the first core clock edge after reset release starts a card clock period, so card_clk and rise_stb are 1 in the first cycle after release.
- R2: With data_mode = 0 and slow_card = 0, the card clock period is div_val + 2 core cycles over the full 11-bit range (div_val 0 gives 2, 623 gives 625, 0x7FF gives 2049).
- R3: With data_mode = 1 and slow_card = 0, only div_val[2:0] is used and the period is div_val[2:0] + 2 core cycles (div_val 623 or 0x7FF gives 9, div_val 5 gives 7).
- R4: With slow_card = 1, the period is div_val + 2 core cycles whatever the value of data_mode.
- R5: A period of N core cycles has card_clk high for ceil(N/2) cycles followed by low for floor(N/2) cycles; for odd N the high phase is one cycle longer.
- R6: rise_stb is 1 for exactly the first high cycle of each period and fall_stb for exactly the first low cycle; the two are never 1 together and no card_clk edge occurs without its strobe.
- R7: div_val, data_mode and slow_card are sampled only on the core edge that starts a new period; a change during a period leaves the rest of that period at the old ratio, and the following period uses the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 11 | Divisor; ratio is selected divisor plus two |
| data_mode | input | 1 | 1 = data mode (short divisor), 0 = identification mode |
| slow_card | input | 1 | 1 = always use the full divisor |
| card_clk | output | 1 | Divided card clock |
| rise_stb | output | 1 | High for one core cycle as card_clk goes high |
| fall_stb | output | 1 | High for one core cycle as card_clk goes low |

## Verification
The ratio is tried with the smallest divisor (ratio 2, a toggle every cycle), small odd and even ratios that expose the duty split, the identification value 623 and the full 0x7FF, which together separate a correct plus-two offset and full-width count from truncation or off-by-one errors. The same divisors are repeated in data mode with and without the override, so a wrong mask, a mask applied in the wrong mode, or an ignored override each produce a distinct period. A mid-period reprogram from a long to a short ratio shows whether the new value is applied early, which would shorten the running period. A behavioural queue model predicts every output bit on every cycle across all of these.

// File: rtl/sd_clkdiv.sv
module sd_clkdiv #(
  parameter int DIV_W     = 11,
  parameter int DATA_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             data_mode,
  input  logic             slow_card,
  output logic             card_clk,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int RATIO_W = DIV_W + 1;

  logic [RATIO_W-1:0] cnt_q, ratio_q, hi_len, next_ratio;
  logic [DIV_W-1:0]   eff_div;
  logic               clk_q, rise_q, fall_q, at_end, at_fall;

  assign eff_div    = (data_mode && !slow_card)
                    ? {{(DIV_W-DATA_BITS){1'b0}}, div_val[DATA_BITS-1:0]}
                    : div_val;
  assign next_ratio = RATIO_W'(eff_div) + RATIO_W'(2);
  assign hi_len     = (ratio_q + RATIO_W'(1)) >> 1;
  assign at_end     = (cnt_q == ratio_q - RATIO_W'(1));
  assign at_fall    = !at_end && (cnt_q + RATIO_W'(1) == hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RATIO_W'(1);
      ratio_q <= RATIO_W'(2);
      clk_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= at_end;
      fall_q <= at_fall;
      if (at_end) begin
        cnt_q   <= '0;
        ratio_q <= next_ratio;
        clk_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
        if (at_fall) clk_q <= 1'b0;
      end
    end
  end

  assign card_clk = clk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;
endmodule

// File: rtl/sd_clkdiv_chk.sv
module sd_clkdiv_chk #(
  parameter int RATIO_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               card_clk,
  input logic               rise_stb,
  input logic               fall_stb,
  input logic [RATIO_W-1:0] ratio_q
);
  logic [RATIO_W-1:0] hi_cnt, lo_cnt;
  logic               started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      started <= 1'b0;
    end else if (rise_stb) begin
      hi_cnt  <= RATIO_W'(1);
      lo_cnt  <= '0;
      started <= 1'b1;
    end else if (card_clk) begin
      hi_cnt <= hi_cnt + RATIO_W'(1);
    end else begin
      lo_cnt <= lo_cnt + RATIO_W'(1);
    end
  end

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= RATIO_W'(2)) && (ratio_q <= RATIO_W'((1 << (RATIO_W-1)) + 1))); // R2
  AST_DUTY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && started) |-> ((hi_cnt == lo_cnt) || (hi_cnt == lo_cnt + RATIO_W'(1)))); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R6
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> card_clk); // R6
  AST_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !card_clk); // R6
  AST_EDGE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> rise_stb); // R6
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_stb |-> $stable(ratio_q)); // R7
endmodule

bind sd_clkdiv sd_clkdiv_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .card_clk(card_clk),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .ratio_q(ratio_q)
);

// File: tb/sd_clkdiv_tb.sv
`timescale 1ns/1ps
module sd_clkdiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] div_val = '0;
  logic        data_mode = 1'b0;
  logic        slow_card = 1'b0;
  logic        card_clk, rise_stb, fall_stb;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sd_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .data_mode(data_mode),
    .slow_card(slow_card), .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // Reference model: a queue of {clk, rise, fall} per core cycle, refilled per period.
  logic [2:0] exp_q [$];
  logic [2:0] exp_now = 3'b000;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_now = 3'b000;
    end else begin
      if (exp_q.size() == 0) begin
        int n;
        int hi;
        n  = ((data_mode && !slow_card) ? (int'(div_val) % 8) : int'(div_val)) + 2;
        hi = (n + 1) / 2;
        for (int i = 0; i < n; i++) begin
          if (i == 0)       exp_q.push_back(3'b110);
          else if (i < hi)  exp_q.push_back(3'b100);
          else if (i == hi) exp_q.push_back(3'b001);
          else              exp_q.push_back(3'b000);
        end
      end
      exp_now = exp_q.pop_front();
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (card_clk !== exp_now[2]) begin
        miscompares++;
        $display("FAIL R5 cycle %0d card_clk act=%b exp=%b", cycles, card_clk, exp_now[2]);
      end
      if ({rise_stb, fall_stb} !== exp_now[1:0]) begin
        miscompares++;
        $display("FAIL R6 cycle %0d rise/fall act=%b%b exp=%b", cycles, rise_stb, fall_stb, exp_now[1:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d act=running exp=finished", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb);
  endtask

  task automatic period(output int p, output int h);
    p = 0;
    h = 1;
    do begin
      @(negedge clk);
      p++;
      if (card_clk && !rise_stb) h++;
    end while (!rise_stb);
  endtask

  task automatic try_ratio(input string tag, input int d, input bit dm, input bit sc, input int n);
    int p, h;
    div_val = 11'(d); data_mode = dm; slow_card = sc;
    wait_rise();
    period(p, h);
    chk({tag, " period"}, p, n);
    chk("R5 high phase", h, (n + 1) / 2);
  endtask

  initial begin
    int p, h;
    repeat (4) @(negedge clk);
    chk("R1 card_clk in reset", int'(card_clk), 0);
    chk("R1 strobes in reset", int'({rise_stb, fall_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first rise after release", int'({card_clk, rise_stb}), 3);

    try_ratio("R2 div0",       0,     1'b0, 1'b0, 2);
    try_ratio("R2 div3",       3,     1'b0, 1'b0, 5);
    try_ratio("R5 div1",       1,     1'b0, 1'b0, 3);
    try_ratio("R2 div623",     623,   1'b0, 1'b0, 625);
    try_ratio("R2 divmax",     2047,  1'b0, 1'b0, 2049);
    try_ratio("R3 div623",     623,   1'b1, 1'b0, 9);
    try_ratio("R3 divmax",     2047,  1'b1, 1'b0, 9);
    try_ratio("R3 div5",       5,     1'b1, 1'b0, 7);
    try_ratio("R3 div8",       8,     1'b1, 1'b0, 2);
    try_ratio("R4 data slow",  623,   1'b1, 1'b1, 625);
    try_ratio("R4 id slow",    12,    1'b0, 1'b1, 14);
    try_ratio("R4 data slow6", 6,     1'b1, 1'b1, 8);

    div_val = 11'd20; data_mode = 1'b0; slow_card = 1'b0;
    wait_rise();
    repeat (3) @(negedge clk);
    div_val = 11'd2;
    data_mode = 1'b1;
    period(p, h);
    p = p + 3;
    chk("R7 running period kept", p, 22);
    period(p, h);
    chk("R7 next period new ratio", p, 4);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule